// File: doc/BRIEF.md
# Retriggerable Gated One-Shot Pulse Generator

This block is a clocked model of a retriggerable monostable with two complementary outputs. A pulse starts on one of three trigger events, which are decoded from a low-active gate, a high-active gate and a low-active clear. The pulse lasts a programmable number of clock cycles; that count takes the place of an external timing network. A trigger that arrives while a pulse is running starts the full count again. Holding clear low ends the pulse at once and blocks every trigger.

The three control inputs may change with no relation to the clock. Each passes through its own synchronizer. The block then compares the synchronized level with the level one cycle earlier to find edges, so only the logic level crossing matters. The block has one channel. A design that needs two channels instantiates it twice. It carries no data stream, so every pin is a plain level signal with no handshake.

Top module: `retrig_oneshot`

## Requirements
- R1: With `gate_lo_n` low, a rising edge on `gate_hi` starts a pulse.
- R2: With `gate_hi` high, a falling edge on `gate_lo_n` starts a pulse.
- R3: With `gate_lo_n` low and `gate_hi` high, a rising edge on `clear_n` starts a pulse.
- R4: A trigger during an active pulse reloads the full length, so the pulse becomes (cycles from the first trigger to the last trigger) plus the length. Triggers repeated more often than the length keep `pulse` high without a gap.
- R5: When `clear_n` goes low, `pulse` returns low and ends the pulse early. The change shows on the same clock edge that a trigger from the same input timing would show on.
- R6: While `clear_n` is low, edges on `gate_lo_n` and `gate_hi` start no pulse.
- R7: `pulse_len` is sampled on the edge where a trigger takes effect, and `pulse` then stays high for exactly that many cycles. A later change to `pulse_len` does not alter the pulse. A value of 0 gives no pulse from idle, and it ends an active pulse.
- R8: An input level that is set up before rising edge k shows on `pulse` just after rising edge k+2, which is a fixed latency of two synchronizer stages.
- R9: During reset and after it, `pulse` is 0 and `pulse_n` is 1 with no stray pulse. The input history resets to the idle levels (`gate_lo_n` high, `gate_hi` low, `clear_n` high).
- R10: `pulse_n` is always the complement of `pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gate_lo_n | input | 1 | Low-active trigger gate, asynchronous |
| gate_hi | input | 1 | High-active trigger gate, asynchronous |
| clear_n | input | 1 | Low-active clear; its rising edge can also trigger |
| pulse_len | input | LEN_W (16) | Pulse length in clock cycles |
| pulse | output | 1 | One-shot output, high while a pulse is active |
| pulse_n | output | 1 | Complement of `pulse` |

## Verification
The assertions assume that each control input holds a level for at least two clock cycles, so the synchronizer and the edge detector see every crossing. They also assume that `pulse_len` is stable on the edge where a trigger takes effect. The stimulus changes inputs only on falling clock edges and holds every level for two or more cycles. It changes `pulse_len` only after the load edge, or well before the next trigger. Each expected pulse width is pushed to a scoreboard before the stimulus that produces it. A monitor compares every completed pulse against that queue, and it flags any pulse that was not predicted.

// File: rtl/rto_pkg.sv
`timescale 1ns/1ps
package rto_pkg;
  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_HI_RISE = 2'd1,
    SRC_LO_FALL = 2'd2,
    SRC_CLR_REL = 2'd3
  } rto_src_e;

  typedef struct packed {
    logic clr_n;
    logic hi;
    logic lo_n;
  } rto_lvl_t;

  localparam rto_lvl_t LVL_IDLE = '{clr_n: 1'b1, hi: 1'b0, lo_n: 1'b1};
endpackage

// File: rtl/rto_sync.sv
`timescale 1ns/1ps
module rto_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int AGE_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign dout = chain_q[STAGES-1];

  // Cycles since reset release, saturating, so the delay check never
  // looks back across reset.
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          age_q <= '0;
    else if (age_q != AGE_W'(STAGES))    age_q <= age_q + 1'b1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      assert_sync_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == AGE_W'(STAGES)) |-> (dout == $past(din, 2)));
    end
  endgenerate
endmodule

// File: rtl/rto_trig.sv
`timescale 1ns/1ps
module rto_trig
  import rto_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rto_lvl_t lvl,
  output logic     fire,
  output logic     clr_on
);
  rto_lvl_t prev_q;
  rto_src_e src;
  logic     hi_rise, lo_fall, clr_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= LVL_IDLE;
    else        prev_q <= lvl;
  end

  // Edges are qualified by the present level of the other gate(s).
  assign hi_rise = lvl.hi & ~prev_q.hi & ~lvl.lo_n;
  assign lo_fall = ~lvl.lo_n & prev_q.lo_n & lvl.hi;
  assign clr_rel = lvl.clr_n & ~prev_q.clr_n & ~lvl.lo_n & lvl.hi;

  always_comb begin
    if (clr_rel)      src = SRC_CLR_REL;
    else if (lo_fall) src = SRC_LO_FALL;
    else if (hi_rise) src = SRC_HI_RISE;
    else              src = SRC_NONE;
  end

  // A held clear masks every trigger source.
  assign clr_on = lvl.clr_n;
  assign fire   = clr_on && (src != SRC_NONE);

  assert_release_fires_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lvl.clr_n) && !lvl.lo_n && lvl.hi) |-> fire);

  assert_hi_edge_fires_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lvl.hi) && !lvl.lo_n && lvl.clr_n) |-> fire);

  assert_lo_edge_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lvl.lo_n) && lvl.hi && lvl.clr_n) |-> fire);
endmodule

// File: rtl/rto_timer.sv
`timescale 1ns/1ps
module rto_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             clr_on,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             act_q;

  always_comb begin
    if (!clr_on)           cnt_d = '0;
    else if (fire)         cnt_d = len;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= (cnt_d != '0);
    end
  end

  assign active = act_q;

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_on |=> (!active && cnt_q == '0));

  assert_load_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr_on) |=> (cnt_q == $past(len)));

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on && !fire && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt_q == '0) |=> !active);
endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
  import rto_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_lo_n,
  input  logic             gate_hi,
  input  logic             clear_n,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             pulse,
  output logic             pulse_n
);
  localparam int LVL_W = $bits(rto_lvl_t);

  rto_lvl_t raw, synced;
  logic     fire, clr_on, active;

  assign raw = '{clr_n: clear_n, hi: gate_hi, lo_n: gate_lo_n};

  rto_sync #(
    .WIDTH  (LVL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(LVL_IDLE)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (raw),
    .dout (synced)
  );

  rto_trig u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (synced),
    .fire  (fire),
    .clr_on(clr_on)
  );

  rto_timer #(.LEN_W(LEN_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .clr_on(clr_on),
    .len   (pulse_len),
    .active(active)
  );

  assign pulse   = active;
  assign pulse_n = ~active;

  assert_outputs_split_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({pulse, pulse_n}) == 1);
endmodule

// File: tb/test_retrig_oneshot.sv
`timescale 1ns/1ps
module test_retrig_oneshot;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          gate_lo_n = 1'b1;
  logic          gate_hi = 1'b0;
  logic          clear_n = 1'b1;
  logic [LW-1:0] pulse_len = '0;
  logic          pulse, pulse_n;

  always #4 clk = ~clk;

  retrig_oneshot #(.LEN_W(LW)) i_retrig_oneshot (
    .clk(clk), .rst_n(rst_n), .gate_lo_n(gate_lo_n), .gate_hi(gate_hi),
    .clear_n(clear_n), .pulse_len(pulse_len), .pulse(pulse), .pulse_n(pulse_n)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    exp_w[$];
  string exp_tag[$];
  int    run = 0;

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_pulse(string tag, int w);
    exp_w.push_back(w);
    exp_tag.push_back(tag);
  endtask

  task automatic expect_low(string tag, int n);
    repeat (n) begin
      @(negedge clk);
      check(tag, int'(pulse), 0);
    end
  endtask

  // Monitor: complement on every cycle, pulse widths against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R10 complement", int'(pulse_n), int'(!pulse));
      if (pulse) run++;
      else if (run > 0) begin
        if (exp_w.size() == 0) check("R9 unexpected pulse width", run, 0);
        else check(exp_tag.pop_front(), run, exp_w.pop_front());
        run = 0;
      end
    end
  end

  initial begin
    #(8 * 200000);
    check("watchdog expired", 1, 0);
    summary();
  end

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      check("R9 reset pulse", int'(pulse), 0);
      check("R9 reset pulse_n", int'(pulse_n), 1);
    end
    rst_n = 1'b1;
    expect_low("R9 idle after reset", 10);

    // R1 and R8: gate_hi rise with gate_lo_n low, latency check
    pulse_len = 16'd10;
    gate_lo_n = 1'b0;
    expect_low("R1 lo fall without hi", 4);
    expect_pulse("R1 hi-rise width", 10);
    gate_hi = 1'b1;
    @(negedge clk); check("R8 still low after k", int'(pulse), 0);
    @(negedge clk); check("R8 still low after k+1", int'(pulse), 0);
    @(negedge clk); check("R8 high after k+2", int'(pulse), 1);
    tick(20);
    gate_hi = 1'b0; gate_lo_n = 1'b1;
    tick(5);

    // R2: gate_lo_n fall with gate_hi high
    pulse_len = 16'd7;
    gate_hi = 1'b1;
    expect_low("R2 hi rise without lo", 4);
    expect_pulse("R2 lo-fall width", 7);
    gate_lo_n = 1'b0;
    tick(20);
    gate_lo_n = 1'b1; gate_hi = 1'b0;
    tick(5);

    // R6 then R3: gate edges under clear, then clear release triggers
    pulse_len = 16'd12;
    clear_n = 1'b0;
    tick(3);
    gate_lo_n = 1'b0;
    tick(3);
    gate_hi = 1'b1;
    expect_low("R6 gates ignored under clear", 8);
    expect_pulse("R3 clear-release width", 12);
    clear_n = 1'b1;
    tick(25);
    gate_hi = 1'b0;
    tick(5);

    // R4: one retrigger 6 cycles after the first
    pulse_len = 16'd10;
    expect_pulse("R4 retrigger width", 16);
    gate_hi = 1'b1; tick(3);
    gate_hi = 1'b0; tick(3);
    gate_hi = 1'b1; tick(30);
    gate_hi = 1'b0; tick(5);

    // R4: continuous retriggering, no gap
    expect_pulse("R4 held high width", 46);
    for (int k = 0; k < 10; k++) begin
      gate_hi = 1'b1; tick(2);
      gate_hi = 1'b0; tick(2);
    end
    tick(60);

    // R5: early clear and override
    pulse_len = 16'd30;
    expect_pulse("R5 early clear width", 8);
    gate_hi = 1'b1; tick(8);
    clear_n = 1'b0; tick(2);
    gate_hi = 1'b0; tick(3);
    gate_hi = 1'b1;
    expect_low("R5 clear overrides trigger", 8);
    gate_hi = 1'b0; clear_n = 1'b1;
    expect_low("R5 release with hi low", 6);

    // R7: length latched at load
    pulse_len = 16'd9;
    expect_pulse("R7 latched length", 9);
    gate_hi = 1'b1; tick(3);
    pulse_len = 16'd50; tick(20);
    gate_hi = 1'b0; tick(5);

    // R7: zero length from idle and as a retrigger
    pulse_len = 16'd0;
    gate_hi = 1'b1;
    expect_low("R7 zero length idle", 10);
    gate_hi = 1'b0; tick(3);
    pulse_len = 16'd20;
    expect_pulse("R7 zero retrigger ends pulse", 5);
    gate_hi = 1'b1; tick(3);
    gate_hi = 1'b0; tick(2);
    pulse_len = 16'd0;
    gate_hi = 1'b1; tick(30);
    gate_hi = 1'b0; gate_lo_n = 1'b1;
    tick(5);

    check("R4 scoreboard drained", exp_w.size(), 0);
    summary();
  end
endmodule